// File: doc/BRIEF.md
# Byte-coded register command sequencer

The block walks a list of byte-coded commands held in a small memory and turns it into management register writes. Each write goes out on a request/ready handshake as a 5-bit device address, a 5-bit register offset, a flag that marks a PHY register rather than a switch register, and a 16-bit data word. A start pulse makes the block fetch from address 0. It keeps fetching one byte per cycle until it reaches a stop byte, which ends the run with a done pulse, or an unsupported opcode, which halts it with an error flag.

In every command byte the top three bits select the opcode and the low five bits are its operand. Opcode 001 loads a sticky device address. Opcode 011 writes a data word to that device at the offset given by the operand. Opcode 100 fans one offset and data word out to every port selected in a 13-bit port bitmap, and each selected port is addressed by its own number. Data words are stored low byte first. The memory read is combinational: `mem_data` reflects `mem_addr` in the same cycle.

Top module: `cmdlist_writer`

## Requirements
- R1: While reset is held, and right after it, `busy`, `done`, `err` and `wr_req` are all low.
- R2: A `start` pulse while idle begins fetching at address 0 with `busy` high. A `start` pulse while busy is ignored, so no command is repeated.
- R3: A command byte 001ddddd (0x20 + d) sets the current device address to d. The address stays in force for all later single writes until another such byte appears, and it is cleared to 0 at each start.
- R4: A command byte 011ooooo (0x60 + o), followed by a data low byte and a data high byte, issues exactly one write with `wr_dev` equal to the current device, `wr_off` = o, `wr_phy` = 0 and the 16-bit data word.
- R5: A command byte 100hhhhh (0x80 + h) starts a multiple write. The operand h holds bitmap bits 12..8, and the next byte holds bits 7..0. The byte after that is the target: 010ooooo means a switch register at offset o, and 100ooooo means a PHY register (`wr_phy` = 1) at offset o. A data low byte and a data high byte follow. The block then issues one write per set bitmap bit, in ascending port order, with `wr_dev` equal to the port number. The current device address is left unchanged.
- R6: A multiple write whose bitmap has no set bit within the implemented ports issues no write, and fetching continues with the next command.
- R7: While `wr_req` is high and `wr_ready` is low, `wr_req`, `wr_dev`, `wr_off`, `wr_phy` and `wr_data` hold their values. The next write starts only after a cycle in which both `wr_req` and `wr_ready` are high.
- R8: The byte 0x00 ends the list. `busy` drops, `done` is high for exactly one cycle and `err` stays low.
- R9: Any other command byte halts the list with `err` high, no `done` and no further writes. This covers top bits 110 or 111 (0xC0 to 0xFF), 0x01 to 0x1F, 0x40 to 0x5F and 0xA0 to 0xBF, and also a multiple-write target byte whose top three bits are neither 010 nor 100. `err` holds until the next start clears it.
- R10: Bitmap bits at or above the parameter NPORT (default 12, so ports 0 to 11) are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin walking the list from address 0 |
| mem_addr | output | ADDR_W | Command memory read address |
| mem_data | input | 8 | Command byte at `mem_addr`, same cycle |
| wr_req | output | 1 | Write transaction valid |
| wr_ready | input | 1 | Write transaction accepted when high with `wr_req` |
| wr_dev | output | 5 | Target device address |
| wr_off | output | 5 | Target register offset |
| wr_phy | output | 1 | 1 = PHY register, 0 = switch register |
| wr_data | output | 16 | Write data |
| busy | output | 1 | A list is being walked |
| done | output | 1 | One-cycle pulse when a stop byte is reached |
| err | output | 1 | Sticky flag: the list halted on an unsupported byte |

## Verification
The assertions assume that `wr_ready` is only ever a plain level sampled at the clock, and that the memory answers combinationally, so a command byte is valid in the same cycle its address appears. The bench drives `wr_ready` and `start` only on falling edges. It holds the command list in an array that it writes only while the block is idle, and it fills unused memory with an illegal byte so that a fetch past the end of a list shows up as an error. Ready is applied in two patterns, always high and high only one cycle in three, so that the hold rule is exercised under long stalls inside multiple writes.

// File: rtl/cmdlist_writer.sv
module cmdlist_writer #(
  parameter int ADDR_W = 8,
  parameter int NPORT  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [7:0]        mem_data,
  output logic              wr_req,
  input  logic              wr_ready,
  output logic [4:0]        wr_dev,
  output logic [4:0]        wr_off,
  output logic              wr_phy,
  output logic [15:0]       wr_data,
  output logic              busy,
  output logic              done,
  output logic              err
);
  localparam logic [NPORT-1:0] ONE = NPORT'(1);

  typedef enum logic [2:0] {S_IDLE, S_CMD, S_MAPLO, S_TGT, S_DLO, S_DHI, S_WR} st_t;

  st_t              st;
  logic [ADDR_W-1:0] pc;
  logic [4:0]       cur_dev, off;
  logic             phy, multi, err_q, done_q;
  logic [15:0]      data;
  logic [12:0]      pmap;
  logic [NPORT-1:0] pend, pend_next;
  logic [4:0]       pick;

  always_comb begin
    pick = 5'd0;
    for (int i = NPORT - 1; i >= 0; i--)
      if (pend[i]) pick = 5'(i);
  end

  assign pend_next = pend & (pend - ONE);
  assign mem_addr  = pc;
  assign wr_req    = (st == S_WR);
  assign wr_dev    = multi ? pick : cur_dev;
  assign wr_off    = off;
  assign wr_phy    = phy;
  assign wr_data   = data;
  assign busy      = (st != S_IDLE);
  assign done      = done_q;
  assign err       = err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; pc <= '0; cur_dev <= '0; off <= '0; phy <= 1'b0;
      multi <= 1'b0; err_q <= 1'b0; done_q <= 1'b0; data <= '0;
      pmap <= '0; pend <= '0;
    end else begin
      done_q <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          pc <= '0; err_q <= 1'b0; cur_dev <= '0; st <= S_CMD;
        end
        S_CMD: begin
          pc <= pc + 1'b1;
          case (mem_data[7:5])
            3'b000: begin
              if (mem_data[4:0] == 5'd0) done_q <= 1'b1;
              else err_q <= 1'b1;
              st <= S_IDLE;
            end
            3'b001: cur_dev <= mem_data[4:0];
            3'b011: begin
              off <= mem_data[4:0]; phy <= 1'b0; multi <= 1'b0; st <= S_DLO;
            end
            3'b100: begin
              pmap[12:8] <= mem_data[4:0]; multi <= 1'b1; st <= S_MAPLO;
            end
            default: begin
              err_q <= 1'b1; st <= S_IDLE;
            end
          endcase
        end
        S_MAPLO: begin
          pmap[7:0] <= mem_data; pc <= pc + 1'b1; st <= S_TGT;
        end
        S_TGT: begin
          pc <= pc + 1'b1;
          off <= mem_data[4:0];
          phy <= mem_data[7];
          if (mem_data[7:5] == 3'b010 || mem_data[7:5] == 3'b100) st <= S_DLO;
          else begin
            err_q <= 1'b1; st <= S_IDLE;
          end
        end
        S_DLO: begin
          data[7:0] <= mem_data; pc <= pc + 1'b1; st <= S_DHI;
        end
        S_DHI: begin
          data[15:8] <= mem_data; pc <= pc + 1'b1;
          if (!multi) st <= S_WR;
          else if (pmap[NPORT-1:0] != '0) begin
            pend <= pmap[NPORT-1:0]; st <= S_WR;
          end else st <= S_CMD;
        end
        S_WR: if (wr_ready) begin
          if (!multi) st <= S_CMD;
          else begin
            pend <= pend_next;
            if (pend_next == '0) st <= S_CMD;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req && !wr_ready |=> wr_req && $stable(wr_dev) && $stable(wr_off)
                            && $stable(wr_phy) && $stable(wr_data));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_clean_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && !err);

  assert_err_halt_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !busy && !wr_req && !done);

  assert_start_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start && !(st == S_CMD && mem_data == 8'h00) |=> busy);
endmodule

// File: tb/cmdlist_writer_test.sv
module cmdlist_writer_test;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, wr_ready = 1'b1;
  logic [7:0] mem_addr, mem_data;
  logic wr_req, wr_phy, busy, done, err;
  logic [4:0] wr_dev, wr_off;
  logic [15:0] wr_data;

  logic [7:0] mem [256];
  assign mem_data = mem[mem_addr];

  cmdlist_writer uut (.clk, .rst_n, .start, .mem_addr, .mem_data, .wr_req,
    .wr_ready, .wr_dev, .wr_off, .wr_phy, .wr_data, .busy, .done, .err);

  always #2 clk = ~clk;

  int n_run = 0, n_fail = 0, cycles = 0;
  int rdy_mode = 0, tick = 0, ngot = 0, nexp = 0, stall_bad = 0;
  logic [26:0] got [64];
  logic [26:0] expw [64];
  logic prev_stall = 1'b0;
  logic [26:0] prev_w = '0;

  function automatic logic [26:0] pk(input logic [4:0] d, input logic [4:0] o,
                                     input logic p, input logic [15:0] v);
    return {d, o, p, v};
  endfunction

  always @(negedge clk) begin
    tick++;
    wr_ready = (rdy_mode == 0) ? 1'b1 : (tick % 3 == 0);
    if (prev_stall && !(wr_req && pk(wr_dev, wr_off, wr_phy, wr_data) == prev_w))
      stall_bad++;
    prev_stall = wr_req && !wr_ready;
    prev_w = pk(wr_dev, wr_off, wr_phy, wr_data);
    if (wr_req && wr_ready) begin
      if (ngot < 64) got[ngot] = prev_w;
      ngot++;
    end
  end

  task automatic summary;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected < 150000", cycles);
      summary();
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic clear_list;
    for (int i = 0; i < 256; i++) mem[i] = 8'hE0;
    nexp = 0;
  endtask

  task automatic put(input int a, input logic [7:0] b);
    mem[a] = b;
  endtask

  task automatic expect_w(input logic [4:0] d, input logic [4:0] o, input logic p,
                          input logic [15:0] v);
    expw[nexp] = pk(d, o, p, v);
    nexp++;
  endtask

  task automatic pulse_start;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic wait_idle(input string req);
    int n = 0;
    while (busy && n < 3000) begin
      @(negedge clk); n++;
    end
    check({req, " finishes"}, 32'(busy), 32'd0);
  endtask

  task automatic compare_log(input string req);
    check({req, " write count"}, ngot, nexp);
    for (int i = 0; i < nexp && i < ngot; i++)
      check({req, " write content"}, 32'(got[i]), 32'(expw[i]));
    check("R7 stall hold", stall_bad, 0);
  endtask

  task automatic run_list(input string req, input logic exp_done, input logic exp_err);
    ngot = 0; stall_bad = 0;
    pulse_start();
    check({req, " busy after start"}, 32'(busy), 32'd1);
    wait_idle(req);
    check({req, " done"}, 32'(done), 32'(exp_done));
    check({req, " err"}, 32'(err), 32'(exp_err));
    @(negedge clk);
    check({req, " done one cycle R8"}, 32'(done), 32'd0);
    compare_log(req);
  endtask

  task automatic t_reset;
    check("R1 busy", 32'(busy), 32'd0);
    check("R1 done", 32'(done), 32'd0);
    check("R1 err", 32'(err), 32'd0);
    check("R1 wr_req", 32'(wr_req), 32'd0);
  endtask

  task automatic t_single;
    clear_list();
    put(0, 8'h23); put(1, 8'h65); put(2, 8'hEF); put(3, 8'hE3); put(4, 8'h00);
    expect_w(5'd3, 5'd5, 1'b0, 16'hE3EF);
    run_list("R4", 1'b1, 1'b0);
  endtask

  task automatic t_sticky;
    clear_list();
    put(0, 8'h3C); put(1, 8'h7A); put(2, 8'h40); put(3, 8'hF9);
    put(4, 8'h7B); put(5, 8'h34); put(6, 8'h12);
    put(7, 8'h20); put(8, 8'h61); put(9, 8'h01); put(10, 8'h00); put(11, 8'h00);
    expect_w(5'h1C, 5'h1A, 1'b0, 16'hF940);
    expect_w(5'h1C, 5'h1B, 1'b0, 16'h1234);
    expect_w(5'h00, 5'h01, 1'b0, 16'h0001);
    run_list("R3", 1'b1, 1'b0);
  endtask

  task automatic t_multi(input int mode);
    rdy_mode = mode;
    clear_list();
    put(0, 8'h21);
    put(1, 8'h81); put(2, 8'hA5); put(3, 8'h80); put(4, 8'h00); put(5, 8'h91);
    put(6, 8'h76); put(7, 8'h00); put(8, 8'h80);
    put(9, 8'h00);
    expect_w(5'd0, 5'd0, 1'b1, 16'h9100);
    expect_w(5'd2, 5'd0, 1'b1, 16'h9100);
    expect_w(5'd5, 5'd0, 1'b1, 16'h9100);
    expect_w(5'd7, 5'd0, 1'b1, 16'h9100);
    expect_w(5'd8, 5'd0, 1'b1, 16'h9100);
    expect_w(5'd1, 5'h16, 1'b0, 16'h8000);
    run_list(mode == 0 ? "R5" : "R5 R7 stalled", 1'b1, 1'b0);
    rdy_mode = 0;
  endtask

  task automatic t_empty;
    clear_list();
    put(0, 8'h80); put(1, 8'h00); put(2, 8'h4B); put(3, 8'h11); put(4, 8'h22);
    put(5, 8'h00);
    run_list("R6", 1'b1, 1'b0);
  endtask

  task automatic t_mask;
    clear_list();
    put(0, 8'h90); put(1, 8'h02); put(2, 8'h4D); put(3, 8'h40); put(4, 8'h00);
    put(5, 8'h00);
    expect_w(5'd1, 5'h0D, 1'b0, 16'h0040);
    run_list("R10", 1'b1, 1'b0);
  endtask

  task automatic t_illegal(input logic [7:0] bad);
    clear_list();
    put(0, 8'h25); put(1, 8'h61); put(2, 8'h01); put(3, 8'h00);
    put(4, bad);
    put(5, 8'h62); put(6, 8'h02); put(7, 8'h00); put(8, 8'h00);
    expect_w(5'd5, 5'd1, 1'b0, 16'h0001);
    run_list("R9", 1'b0, 1'b1);
    repeat (5) @(negedge clk);
    check("R9 err sticky", 32'(err), 32'd1);
    check("R9 no later writes", ngot, 1);
  endtask

  task automatic t_bad_target;
    clear_list();
    put(0, 8'h80); put(1, 8'h01); put(2, 8'hC0); put(3, 8'h00); put(4, 8'h91);
    put(5, 8'h00);
    run_list("R9 target", 1'b0, 1'b1);
  endtask

  task automatic t_busy_start;
    rdy_mode = 1;
    clear_list();
    put(0, 8'h2A); put(1, 8'h63); put(2, 8'h55); put(3, 8'hAA); put(4, 8'h00);
    expect_w(5'h0A, 5'd3, 1'b0, 16'hAA55);
    ngot = 0; stall_bad = 0;
    pulse_start();
    check("R2 busy", 32'(busy), 32'd1);
    pulse_start();
    pulse_start();
    wait_idle("R2");
    check("R2 done", 32'(done), 32'd1);
    @(negedge clk);
    compare_log("R2 restart ignored");
    rdy_mode = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single();
    t_sticky();
    t_multi(0);
    t_multi(1);
    t_empty();
    t_mask();
    t_illegal(8'hC3);
    t_illegal(8'hE0);
    t_illegal(8'h01);
    t_bad_target();
    t_single();
    t_busy_start();
    summary();
  end
endmodule